// File: doc/BRIEF.md
# Edge-pulse isolation link codec

This block carries one logic level over a channel that can only pass short pulses. The transmit half watches a slow input. Each rising transition becomes a pulse on a set line, and each falling transition becomes a pulse on a reset line. When the input holds still, the transmit half keeps the far side correct by sending a refresh pulse at a fixed interval. The refresh pulse has the polarity of the present level.

The receive half keeps the level in a set/reset latch. A watchdog counts the cycles since the last pulse of either kind. When that silence grows too long, the receive half assumes the sender is unpowered and drives its output to the safe level, high. Any later pulse gives control back to the latch at once.

Both halves run on one clock. Pulse width, refresh interval and watchdog timeout are parameters counted in clock cycles. The two halves share a top level, but their pulse lines are separate ports, so the channel between them is wired outside the block. The watchdog timeout must exceed the refresh interval plus the pulse width.

Top module: `pulse_link_codec`

## Requirements
- R1: A rising transition of `din` produces a pulse on `tx_set`, and a falling transition produces a pulse on `tx_rst`. The pulse starts exactly 3 clock cycles after the input change: two for synchronisation and one output register.
- R2: Every transmitted pulse stays high for exactly PULSE_W cycles, and `tx_set` and `tx_rst` are never high together.
- R3: While `din` is unchanged, the start of each refresh pulse follows the start of the previous pulse by exactly REFRESH_CYC cycles. A refresh pulse is on `tx_set` when the level is 1 and on `tx_rst` when it is 0.
- R4: Every pulse sent for an input transition restarts the refresh interval, so the first refresh pulse after it starts REFRESH_CYC cycles later.
- R5: While reset is asserted both transmit lines are low. After reset is released, the first transmitted pulse carries the polarity of the current input level.
- R6: `rx_set` alone makes `dout` 1, and `rx_rst` alone makes `dout` 0, on the next clock edge.
- R7: When `rx_set` and `rx_rst` are high in the same cycle, the latch keeps its value and `collision` is high for the following cycle only.
- R8: If neither receive line has been high for WDOG_CYC cycles, `wd_tripped` rises and `dout` is forced to 1. At WDOG_CYC-1 cycles of silence, neither has happened yet.
- R9: Any received pulse reloads the watchdog. If the watchdog had tripped, `wd_tripped` clears on the next edge and `dout` follows the latch again.
- R10: From reset until the first received pulse, `wd_tripped` is 1 and `dout` is 1.
- R11: With the transmit lines looped to the receive lines and the input idle, the watchdog never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Asynchronous level to transmit |
| tx_set | output | 1 | Transmit pulse: level went (or is) high |
| tx_rst | output | 1 | Transmit pulse: level went (or is) low |
| rx_set | input | 1 | Received set pulse |
| rx_rst | input | 1 | Received reset pulse |
| dout | output | 1 | Recovered level, forced high on watchdog timeout |
| wd_tripped | output | 1 | Watchdog timeout active |
| collision | output | 1 | Both receive lines were high in the previous cycle |

## Verification
A corrupted refresh counter shows on the transmit lines within one refresh interval: the next pulse arrives early or late, or on the wrong line. A wrong latch bit shows on `dout` one cycle after the receive pulse that should have set it. A watchdog counter that is off by even one cycle moves the rise of `wd_tripped` away from exactly WDOG_CYC quiet cycles, so the bench pins that edge on both sides. Recovery is checked one cycle after the first pulse that follows a timeout.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;

  // Decoded pair of pulse lines, bit 0 = set line, bit 1 = reset line.
  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_SET  = 2'b01,
    PK_RST  = 2'b10,
    PK_BOTH = 2'b11
  } pulse_kind_e;

  // Transmit start-up phases: two cycles to fill the synchroniser,
  // one cycle to announce the level, then normal operation.
  typedef enum logic [1:0] {
    TX_FILL0 = 2'b00,
    TX_FILL1 = 2'b01,
    TX_BOOT  = 2'b10,
    TX_RUN   = 2'b11
  } tx_phase_e;

endpackage

// File: rtl/pl_rst_sync.sv
module pl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/pl_tx.sv
module pl_tx
  import pulse_link_pkg::*;
#(
  parameter int PULSE_W     = 1,
  parameter int REFRESH_CYC = 64
) (
  input  logic clk,
  input  logic srst_n,
  input  logic din,
  output logic set_o,
  output logic rst_o
);

  localparam int IW  = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam int PWW = $clog2(PULSE_W + 1);
  localparam logic [IW-1:0]  IDLE_LAST = IW'(REFRESH_CYC - 1);
  localparam logic [PWW-1:0] PW_LOAD   = PWW'(PULSE_W - 1);

  // synchroniser and level history
  logic s1_q, s2_q, prev_q;
  tx_phase_e phase_q, phase_d;
  logic prev_d;

  // refresh timer
  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  // pulse shaper
  logic [PWW-1:0] pw_q, pw_d;
  logic set_q, set_d, rst_q, rst_d;

  logic edge_hit, boot_hit, refresh_hit, fire;
  pulse_kind_e kind;

  always_comb begin
    edge_hit    = (phase_q == TX_RUN) && (s2_q != prev_q);
    boot_hit    = (phase_q == TX_BOOT);
    refresh_hit = (phase_q == TX_RUN) && !edge_hit && (idle_q == IDLE_LAST);
    fire        = edge_hit || boot_hit || refresh_hit;
    kind        = !fire ? PK_NONE : (s2_q ? PK_SET : PK_RST);
  end

  always_comb begin
    phase_d = phase_q;
    if (phase_q != TX_RUN) phase_d = tx_phase_e'(phase_q + 2'd1);

    prev_d = prev_q;
    if (phase_q == TX_BOOT || phase_q == TX_RUN) prev_d = s2_q;

    idle_en = (phase_q == TX_RUN) || fire;
    idle_d  = fire ? '0 : idle_q + IW'(1);

    pw_d  = pw_q;
    set_d = set_q;
    rst_d = rst_q;
    if (fire) begin
      set_d = (kind == PK_SET);
      rst_d = (kind == PK_RST);
      pw_d  = PW_LOAD;
    end else if (pw_q != '0) begin
      pw_d = pw_q - PWW'(1);
    end else begin
      set_d = 1'b0;
      rst_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      phase_q <= TX_FILL0;
      idle_q  <= '0;
      pw_q    <= '0;
      set_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      s1_q    <= din;
      s2_q    <= s1_q;
      prev_q  <= prev_d;
      phase_q <= phase_d;
      if (idle_en) idle_q <= idle_d;
      pw_q    <= pw_d;
      set_q   <= set_d;
      rst_q   <= rst_d;
    end
  end

  assign set_o = set_q;
  assign rst_o = rst_q;

endmodule

// File: rtl/pl_rx.sv
module pl_rx
  import pulse_link_pkg::*;
#(
  parameter int WDOG_CYC = 160
) (
  input  logic clk,
  input  logic srst_n,
  input  logic set_i,
  input  logic rst_i,
  output logic level_o,
  output logic tripped_o,
  output logic clash_o
);

  localparam int WW = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
  localparam logic [WW-1:0] WD_LAST = WW'(WDOG_CYC - 1);

  pulse_kind_e kind;
  logic latch_q, latch_d;
  logic trip_q, trip_d;
  logic clash_q, clash_d;
  logic [WW-1:0] wd_q, wd_d;
  logic          wd_en;

  always_comb begin
    kind = pulse_kind_e'({rst_i, set_i});

    latch_d = latch_q;
    case (kind)
      PK_SET:  latch_d = 1'b1;
      PK_RST:  latch_d = 1'b0;
      default: latch_d = latch_q;
    endcase
    clash_d = (kind == PK_BOTH);

    trip_d = trip_q;
    wd_d   = wd_q;
    wd_en  = 1'b1;
    if (kind != PK_NONE) begin
      wd_d   = '0;
      trip_d = 1'b0;
    end else if (trip_q) begin
      wd_en  = 1'b0;
    end else if (wd_q == WD_LAST) begin
      trip_d = 1'b1;
      wd_en  = 1'b0;
    end else begin
      wd_d = wd_q + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      latch_q <= 1'b1;
      trip_q  <= 1'b1;
      clash_q <= 1'b0;
      wd_q    <= '0;
    end else begin
      latch_q <= latch_d;
      trip_q  <= trip_d;
      clash_q <= clash_d;
      if (wd_en) wd_q <= wd_d;
    end
  end

  assign level_o   = trip_q | latch_q;
  assign tripped_o = trip_q;
  assign clash_o   = clash_q;

endmodule

// File: rtl/pulse_link_codec.sv
module pulse_link_codec #(
  parameter int PULSE_W     = 1,
  parameter int REFRESH_CYC = 64,
  parameter int WDOG_CYC    = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_rst,
  input  logic rx_set,
  input  logic rx_rst,
  output logic dout,
  output logic wd_tripped,
  output logic collision
);

  logic srst_n;

  pl_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pl_tx #(
    .PULSE_W     (PULSE_W),
    .REFRESH_CYC (REFRESH_CYC)
  ) u_tx (
    .clk    (clk),
    .srst_n (srst_n),
    .din    (din),
    .set_o  (tx_set),
    .rst_o  (tx_rst)
  );

  pl_rx #(
    .WDOG_CYC (WDOG_CYC)
  ) u_rx (
    .clk       (clk),
    .srst_n    (srst_n),
    .set_i     (rx_set),
    .rst_i     (rx_rst),
    .level_o   (dout),
    .tripped_o (wd_tripped),
    .clash_o   (collision)
  );

endmodule

// File: rtl/pulse_link_chk.sv
module pulse_link_chk #(
  parameter int PULSE_W     = 1,
  parameter int REFRESH_CYC = 64,
  parameter int WDOG_CYC    = 160
) (
  input logic clk,
  input logic rst_n,
  input logic tx_set,
  input logic tx_rst,
  input logic rx_set,
  input logic rx_rst,
  input logic dout,
  input logic wd_tripped,
  input logic collision
);

  int  tx_low;
  logic tx_seen;
  int  rx_gap;
  logic rx_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_low  <= 0;
      tx_seen <= 1'b0;
      rx_gap  <= 0;
      rx_seen <= 1'b0;
    end else begin
      if (tx_set || tx_rst) begin
        tx_low  <= 0;
        tx_seen <= 1'b1;
      end else if (tx_low < REFRESH_CYC + 4) begin
        tx_low <= tx_low + 1;
      end
      if (rx_set || rx_rst) begin
        rx_gap  <= 0;
        rx_seen <= 1'b1;
      end else if (rx_gap < WDOG_CYC + 4) begin
        rx_gap <= rx_gap + 1;
      end
    end
  end

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set && tx_rst)); // R2
  AST_TX_REFRESH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_seen |-> (tx_low <= REFRESH_CYC - PULSE_W)); // R3
  AST_RX_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && !rx_rst) |=> dout); // R6
  AST_RX_RST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst && !rx_set) |=> !dout); // R6
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && rx_rst) |=> collision); // R7
  AST_CLASH_ONLY_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_set && rx_rst) |=> !collision); // R7
  AST_TRIP_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wd_tripped |-> dout); // R8
  AST_WD_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_seen && rx_gap >= WDOG_CYC) |-> wd_tripped); // R8
  AST_WD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_seen && rx_gap < WDOG_CYC) |-> !wd_tripped); // R9

endmodule

bind pulse_link_codec pulse_link_chk #(
  .PULSE_W     (PULSE_W),
  .REFRESH_CYC (REFRESH_CYC),
  .WDOG_CYC    (WDOG_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_set     (tx_set),
  .tx_rst     (tx_rst),
  .rx_set     (rx_set),
  .rx_rst     (rx_rst),
  .dout       (dout),
  .wd_tripped (wd_tripped),
  .collision  (collision)
);

// File: tb/tb_pulse_link_codec.sv
`timescale 1ns/1ps
module tb_pulse_link_codec;

  localparam int PW  = 2;
  localparam int REF = 40;
  localparam int WD  = 100;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n, din;
  logic tx_set, tx_rst, rx_set, rx_rst, dout, wd_tripped, collision;
  logic inj_mode, inj_s, inj_r, cut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rx_set = inj_mode ? inj_s : (tx_set & ~cut);
  assign rx_rst = inj_mode ? inj_r : (tx_rst & ~cut);

  pulse_link_codec #(.PULSE_W(PW), .REFRESH_CYC(REF), .WDOG_CYC(WD)) dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .tx_set(tx_set), .tx_rst(tx_rst),
    .rx_set(rx_set), .rx_rst(rx_rst),
    .dout(dout), .wd_tripped(wd_tripped), .collision(collision)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference latch model for the receive half
  function automatic logic next_level(input logic cur, input logic s, input logic r);
    if (s && !r) return 1'b1;
    if (r && !s) return 1'b0;
    return cur;
  endfunction

  // change din, measure latency, polarity and width, then stay idle
  task automatic edge_case(input logic v, input int hold);
    int n;
    int w;
    bit extra;
    din = v;
    n = 0;
    while (!(tx_set || tx_rst) && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == LAT, "R1 latency", n, LAT);
    chk(tx_set == v && tx_rst == !v, "R1 polarity", {30'd0, tx_set, tx_rst}, v ? 2 : 1);
    w = 0;
    while ((tx_set || tx_rst) && w < 10) begin
      w++;
      @(negedge clk);
    end
    chk(w == PW, "R2 width", w, PW);
    chk(dout == v, "R6 loopback level", dout, v);
    extra = 0;
    repeat (hold) begin
      @(negedge clk);
      if (tx_set || tx_rst) extra = 1;
    end
    chk(!extra, "R4 no pulse before interval", extra, 0);
  endtask

  task automatic refresh_run(input logic v);
    int n;
    int t;
    int last;
    int cnt;
    bit prevp;
    bit cur;
    bit tripbad;
    din = v;
    n = 0;
    while (!(tx_set || tx_rst) && n < 20) begin
      @(negedge clk);
      n++;
    end
    t = 0; last = 0; cnt = 0; prevp = 1; tripbad = 0;
    repeat (4 * REF + 2) begin
      @(negedge clk);
      t++;
      cur = tx_set | tx_rst;
      if (cur && !prevp) begin
        if (cnt == 0) chk(t - last == REF, "R4 first refresh", t - last, REF);
        else          chk(t - last == REF, "R3 spacing", t - last, REF);
        chk(tx_set == v && tx_rst == !v, "R3 polarity", {30'd0, tx_set, tx_rst}, v ? 2 : 1);
        last = t;
        cnt++;
      end
      prevp = cur;
      if (wd_tripped) tripbad = 1;
    end
    chk(cnt == 4, "R3 refresh count", cnt, 4);
    chk(!tripbad, "R11 healthy idle", tripbad, 0);
    chk(dout == v, "R3 level held", dout, v);
  endtask

  task automatic inject(input logic s, input logic r);
    inj_s = s;
    inj_r = r;
    @(negedge clk);
    inj_s = 0;
    inj_r = 0;
  endtask

  initial begin
    int unsigned r;
    logic lvl;
    logic s;
    logic rr;
    int n;
    void'($urandom(32'd5813));
    rst_n = 0; din = 0; inj_mode = 0; inj_s = 0; inj_r = 0; cut = 0;
    repeat (3) @(negedge clk);
    chk(!tx_set && !tx_rst, "R5 quiet in reset", {30'd0, tx_set, tx_rst}, 0);
    chk(dout && wd_tripped, "R10 reset state", {30'd0, dout, wd_tripped}, 3);
    din = 1;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dout && wd_tripped, "R10 before first pulse", {30'd0, dout, wd_tripped}, 3);
    n = 0;
    while (!(tx_set || tx_rst) && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(tx_set && !tx_rst, "R5 boot polarity", {30'd0, tx_set, tx_rst}, 2);
    repeat (PW + 2) @(negedge clk);
    chk(!wd_tripped, "R9 first pulse clears trip", wd_tripped, 0);

    edge_case(1'b0, 10);
    edge_case(1'b1, 10);
    for (int i = 0; i < 30; i++) begin
      r = $urandom % (REF - PW - 8);
      edge_case(!din, 2 + int'(r));
    end

    refresh_run(1'b0);
    refresh_run(1'b1);

    // cut the looped link: watchdog must trip, reconnect: refresh recovers
    cut = 1;
    repeat (WD + REF + 4) @(negedge clk);
    chk(wd_tripped && dout, "R8 cut link trips", {30'd0, wd_tripped, dout}, 3);
    din = 0;
    repeat (LAT + PW + 1) @(negedge clk);
    cut = 0;
    repeat (REF + 2) @(negedge clk);
    chk(!wd_tripped && dout == 0, "R9 refresh recovers", {30'd0, wd_tripped, dout}, 0);

    // direct receive stimulus
    inj_mode = 1;
    inject(0, 1);
    chk(dout == 0 && !wd_tripped, "R6 reset pulse", dout, 0);
    repeat (WD - 1) @(negedge clk);
    chk(!wd_tripped && dout == 0, "R8 not before timeout", {30'd0, wd_tripped, dout}, 0);
    @(negedge clk);
    chk(wd_tripped && dout, "R8 timeout forces high", {30'd0, wd_tripped, dout}, 3);
    inject(0, 1);
    chk(!wd_tripped && dout == 0, "R9 recovery", {30'd0, wd_tripped, dout}, 0);
    inject(1, 0);
    chk(dout == 1, "R6 set pulse", dout, 1);
    inject(0, 1);
    repeat (WD - 2) @(negedge clk);
    inject(0, 1);
    repeat (WD - 1) @(negedge clk);
    chk(!wd_tripped && dout == 0, "R9 reload", {30'd0, wd_tripped, dout}, 0);

    inject(1, 1);
    chk(dout == 0 && collision, "R7 both holds low", {30'd0, dout, collision}, 1);
    @(negedge clk);
    chk(!collision, "R7 flag one cycle", collision, 0);
    inject(1, 0);
    inject(1, 1);
    chk(dout == 1 && collision, "R7 both holds high", {30'd0, dout, collision}, 3);

    lvl = 1'b1;
    for (int i = 0; i < 40; i++) begin
      r = $urandom;
      s = r[0];
      rr = r[1];
      lvl = next_level(lvl, s, rr);
      inject(s, rr);
      chk(dout == lvl, "R6 random pulses", dout, lvl);
      chk(collision == (s && rr), "R7 random pulses", collision, s && rr);
      repeat (int'(r[9:4])) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule